// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupts

This block is a single general-purpose I/O port of up to 32 pins, controlled through a small 32-bit register bus with an APB-like setup/access handshake. Software sets each pin's output level and its drive enable, and reads back the pin levels after a two-flop synchronizer. Any pin can also be an interrupt source. Software picks level or edge sensitivity, high or low polarity, and enables and masks each pin separately.

Edge events are held in a per-pin latch until software acknowledges them with a write-one-to-clear store. Level sources track the synchronized pin directly. The masked pending vector can be read as a status word, and its OR drives one interrupt line. The debounce offset exists in the map but has no storage and reads as zero.

Top module: `gpio_pin_irq`

## Requirements
- R1: After reset every readable register reads zero, and `pinOut`, `pinOe` and `irqOut` are all zero.
- R2: Writes to offset 0x00 (output level) and 0x04 (drive enable, 1 = output) read back unchanged and appear on `pinOut` and `pinOe` in the cycle after the access phase.
- R3: Offset 0x50 returns the pin levels through two flops. A level change is visible at the second rising clock edge after it, and not before.
- R4: Offsets 0x40 (acknowledge), 0x48 (debounce), every other unlisted offset, and any offset with nonzero low two bits all read zero. Writes to them leave the other registers unchanged.
- R5: When the type bit at 0x34 is 0 (level), status bit n at 0x3C is 1 exactly while the synchronized pin matches its polarity bit at 0x38 (1 = high, 0 = low), the enable bit at 0x30 is 1 and the mask bit at 0x44 is 0.
- R6: When the type bit is 1 (edge), an active transition (rising when polarity is 1, falling when it is 0) sets a latch that stays set until it is acknowledged or the pin is disabled.
- R7: Writing 1 to bit n of offset 0x40 clears pin n's edge latch. Bits written as 0 have no effect, and level sources are unaffected.
- R8: An active edge in the same cycle as an acknowledge write for that pin leaves the latch set.
- R9: A mask bit of 1 hides the pin from the status word and `irqOut`, but the edge latch is kept. The event reappears when the mask bit returns to 0.
- R10: An enable bit of 0 removes the pin from status and drops its edge latch.
- R11: `irqOut` is 1 exactly when the status word at 0x3C is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus select |
| busEnable | input | 1 | Access phase |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid while selected for a read |
| pinIn | input | NUM_PINS | Pin levels from the pads |
| pinOut | output | NUM_PINS | Output levels |
| pinOe | output | NUM_PINS | Drive enables |
| irqOut | output | 1 | Combined interrupt |

## Verification
The two functions that can collide are edge detection and the acknowledge write. They meet when a pin's synchronized edge arrives in the same cycle that a write to 0x40 commits for that pin. The bench provokes this by changing the pin exactly two edges before the access-phase commit, with the latch already set by an earlier edge. It expects the status bit to stay 1. A control run with no coincident edge must clear the bit.

// File: rtl/gpio_pin_irq_pkg.sv
package gpio_pin_irq_pkg;
  // Byte offsets; software depends on these values.
  localparam int OFF_DATA  = 'h00;
  localparam int OFF_DIR   = 'h04;
  localparam int OFF_IEN   = 'h30;
  localparam int OFF_ITYPE = 'h34;
  localparam int OFF_IPOL  = 'h38;
  localparam int OFF_ISTAT = 'h3C;
  localparam int OFF_ACK   = 'h40;
  localparam int OFF_MASK  = 'h44;
  localparam int OFF_DEB   = 'h48;
  localparam int OFF_EXT   = 'h50;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_DIR, SEL_IEN, SEL_ITYPE, SEL_IPOL,
    SEL_ISTAT, SEL_ACK, SEL_MASK, SEL_DEB, SEL_EXT
  } regSel_e;

  typedef struct packed {
    logic    wrData;
    logic    wrDir;
    logic    wrIen;
    logic    wrItype;
    logic    wrIpol;
    logic    wrAck;
    logic    wrMask;
    logic    rdEn;
    regSel_e sel;
  } busCtl_t;
endpackage

// File: rtl/gpio_pin_irq_ctrl.sv
module gpio_pin_irq_ctrl
  import gpio_pin_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busSel,
  input  logic              busEnable,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output busCtl_t           ctl
);
  regSel_e sel;
  logic    wrAccess;

  always_comb begin
    sel = SEL_NONE;
    if (busAddr[1:0] == 2'b00) begin
      if      (busAddr == ADDR_W'(OFF_DATA))  sel = SEL_DATA;
      else if (busAddr == ADDR_W'(OFF_DIR))   sel = SEL_DIR;
      else if (busAddr == ADDR_W'(OFF_IEN))   sel = SEL_IEN;
      else if (busAddr == ADDR_W'(OFF_ITYPE)) sel = SEL_ITYPE;
      else if (busAddr == ADDR_W'(OFF_IPOL))  sel = SEL_IPOL;
      else if (busAddr == ADDR_W'(OFF_ISTAT)) sel = SEL_ISTAT;
      else if (busAddr == ADDR_W'(OFF_ACK))   sel = SEL_ACK;
      else if (busAddr == ADDR_W'(OFF_MASK))  sel = SEL_MASK;
      else if (busAddr == ADDR_W'(OFF_DEB))   sel = SEL_DEB;
      else if (busAddr == ADDR_W'(OFF_EXT))   sel = SEL_EXT;
    end
  end

  assign wrAccess = busSel & busEnable & busWrite;

  always_comb begin
    ctl         = '0;
    ctl.sel     = sel;
    ctl.rdEn    = busSel & ~busWrite;
    ctl.wrData  = wrAccess && (sel == SEL_DATA);
    ctl.wrDir   = wrAccess && (sel == SEL_DIR);
    ctl.wrIen   = wrAccess && (sel == SEL_IEN);
    ctl.wrItype = wrAccess && (sel == SEL_ITYPE);
    ctl.wrIpol  = wrAccess && (sel == SEL_IPOL);
    ctl.wrAck   = wrAccess && (sel == SEL_ACK);
    ctl.wrMask  = wrAccess && (sel == SEL_MASK);
  end
endmodule

// File: rtl/gpio_pin_irq_dp.sv
module gpio_pin_irq_dp
  import gpio_pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  busCtl_t             ctl,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [DATA_W-1:0]   rdata,
  output logic                irqOut,
  output logic [NUM_PINS-1:0] edgeHit,
  output logic [NUM_PINS-1:0] edgeArm,
  output logic [NUM_PINS-1:0] edgeLatch
);
  logic [NUM_PINS-1:0] dataReg, dirReg, ienReg, typeReg, polReg, maskReg;
  logic [NUM_PINS-1:0] syncA, syncB, syncPrev;
  logic [NUM_PINS-1:0] activeNow, activePrev, ackBits, latchNext;
  logic [NUM_PINS-1:0] pending, status;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      dirReg  <= '0;
      ienReg  <= '0;
      typeReg <= '0;
      polReg  <= '0;
      maskReg <= '0;
    end else begin
      if (ctl.wrData)  dataReg <= wdata[NUM_PINS-1:0];
      if (ctl.wrDir)   dirReg  <= wdata[NUM_PINS-1:0];
      if (ctl.wrIen)   ienReg  <= wdata[NUM_PINS-1:0];
      if (ctl.wrItype) typeReg <= wdata[NUM_PINS-1:0];
      if (ctl.wrIpol)  polReg  <= wdata[NUM_PINS-1:0];
      if (ctl.wrMask)  maskReg <= wdata[NUM_PINS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA     <= '0;
      syncB     <= '0;
      syncPrev  <= '0;
      edgeLatch <= '0;
    end else begin
      syncA     <= pinIn;
      syncB     <= syncA;
      syncPrev  <= syncB;
      edgeLatch <= latchNext;
    end
  end

  assign activeNow  = syncB ~^ polReg;
  assign activePrev = syncPrev ~^ polReg;
  assign edgeHit    = activeNow & ~activePrev;
  assign edgeArm    = ienReg & typeReg;
  assign ackBits    = ctl.wrAck ? wdata[NUM_PINS-1:0] : '0;
  assign latchNext  = edgeArm & (edgeHit | (edgeLatch & ~ackBits));

  assign pending = (typeReg & edgeLatch) | (~typeReg & activeNow);
  assign status  = pending & ienReg & ~maskReg;
  assign irqOut  = |status;

  assign pinOut = dataReg;
  assign pinOe  = dirReg;

  always_comb begin
    rdata = '0;
    if (ctl.rdEn) begin
      unique case (ctl.sel)
        SEL_DATA:  rdata = DATA_W'(dataReg);
        SEL_DIR:   rdata = DATA_W'(dirReg);
        SEL_IEN:   rdata = DATA_W'(ienReg);
        SEL_ITYPE: rdata = DATA_W'(typeReg);
        SEL_IPOL:  rdata = DATA_W'(polReg);
        SEL_ISTAT: rdata = DATA_W'(status);
        SEL_MASK:  rdata = DATA_W'(maskReg);
        SEL_EXT:   rdata = DATA_W'(syncB);
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq
  import gpio_pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busEnable,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irqOut
);
  busCtl_t             ctl;
  logic [NUM_PINS-1:0] edgeHit, edgeArm, edgeLatch;

  gpio_pin_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel(busSel), .busEnable(busEnable), .busWrite(busWrite),
    .busAddr(busAddr), .ctl(ctl)
  );

  gpio_pin_irq_dp #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wdata(busWdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .rdata(busRdata), .irqOut(irqOut),
    .edgeHit(edgeHit), .edgeArm(edgeArm), .edgeLatch(edgeLatch)
  );
endmodule

// File: rtl/gpio_pin_irq_chk.sv
module gpio_pin_irq_chk
  import gpio_pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                busSel,
  input logic                busEnable,
  input logic                busWrite,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [DATA_W-1:0]   busWdata,
  input logic [DATA_W-1:0]   busRdata,
  input logic [NUM_PINS-1:0] pinOe,
  input busCtl_t             ctl,
  input logic [NUM_PINS-1:0] edgeHit,
  input logic [NUM_PINS-1:0] edgeArm,
  input logic [NUM_PINS-1:0] edgeLatch
);
  logic wrAcc, mapped;
  assign wrAcc  = busSel && busEnable && busWrite;
  assign mapped = (busAddr == ADDR_W'(OFF_DATA))  || (busAddr == ADDR_W'(OFF_DIR))  ||
                  (busAddr == ADDR_W'(OFF_IEN))   || (busAddr == ADDR_W'(OFF_ITYPE)) ||
                  (busAddr == ADDR_W'(OFF_IPOL))  || (busAddr == ADDR_W'(OFF_ISTAT)) ||
                  (busAddr == ADDR_W'(OFF_MASK))  || (busAddr == ADDR_W'(OFF_EXT));

  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && busAddr == ADDR_W'(OFF_DIR)) |=> pinOe == $past(busWdata[NUM_PINS-1:0]));

  a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && !mapped) |-> busRdata == '0);

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.wrData, ctl.wrDir, ctl.wrIen, ctl.wrItype, ctl.wrIpol, ctl.wrAck, ctl.wrMask}));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic ackHit;
    assign ackHit = wrAcc && busAddr == ADDR_W'(OFF_ACK) && busWdata[i];

    a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rstN)
      $fell(edgeLatch[i]) |-> $past(ackHit || !edgeArm[i]));

    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
      (ackHit && !edgeHit[i]) |=> !edgeLatch[i]);

    a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rstN)
      (edgeHit[i] && edgeArm[i]) |=> edgeLatch[i]);
  end
endmodule

bind gpio_pin_irq gpio_pin_irq_chk #(
  .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busEnable(busEnable),
  .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
  .busRdata(busRdata), .pinOe(pinOe), .ctl(ctl), .edgeHit(edgeHit),
  .edgeArm(edgeArm), .edgeLatch(edgeLatch)
);

// File: tb/gpio_pin_irq_bench.sv
`timescale 1ns/1ps
module gpio_pin_irq_bench;
  localparam int NP = 32;
  logic clk = 1'b0, rstN = 1'b0;
  logic busSel = 0, busEnable = 0, busWrite = 0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [NP-1:0] pinIn = '0, pinOut, pinOe;
  logic irqOut;
  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_pin_irq u_gpio_pin_irq (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busEnable(busEnable),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .irqOut(irqOut)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); busSel = 1; busWrite = 1; busEnable = 0; busAddr = a; busWdata = d;
    @(negedge clk); busEnable = 1;
    @(negedge clk); busSel = 0; busEnable = 0; busWrite = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    busSel = 0;
  endtask

  task automatic setPins(logic [31:0] v);
    @(negedge clk); pinIn = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] levelExp(logic [31:0] en, mask, pol, pins);
    return en & ~mask & (pol ? pins : ~pins) | (en & ~mask & ((pol & pins) | (~pol & ~pins)));
  endfunction

  function automatic logic [31:0] edgeExp(logic [31:0] en, mask, pol, p0, p1);
    return en & ~mask & ((pol & p1 & ~p0) | (~pol & p0 & ~p1));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++; nChecks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, en, mask, pol, p0, p1, ack, exp;
    logic [7:0] offs [10];
    int seed;
    offs = '{8'h00, 8'h04, 8'h30, 8'h34, 8'h38, 8'h3C, 8'h40, 8'h44, 8'h48, 8'h50};
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: reset values
    foreach (offs[k]) begin rd(offs[k], d); check("R1 reset read", d, 0); end
    check("R1 pinOe", pinOe, 0); check("R1 pinOut", pinOut, 0); check("R1 irqOut", {31'b0, irqOut}, 0);

    // R2: output level and drive enable
    for (int i = 0; i < 8; i++) begin
      p0 = $urandom; p1 = $urandom;
      wr(8'h00, p0); wr(8'h04, p1);
      check("R2 pinOut", pinOut, p0); check("R2 pinOe", pinOe, p1);
      rd(8'h00, d); check("R2 data read", d, p0);
      rd(8'h04, d); check("R2 dir read", d, p1);
    end

    // R4: dead offsets read zero and writes to them change nothing
    wr(8'h00, 32'hA5A5_0F0F);
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h48, 32'hFFFF_FFFF); wr(8'h4C, 32'hFFFF_FFFF);
    wr(8'h01, 32'h0000_0000);
    rd(8'h00, d); check("R4 data intact", d, 32'hA5A5_0F0F);
    rd(8'h08, d); check("R4 0x08", d, 0);
    rd(8'h40, d); check("R4 ack reads 0", d, 0);
    rd(8'h48, d); check("R4 debounce reads 0", d, 0);
    rd(8'h01, d); check("R4 unaligned", d, 0);

    // R3: synchronizer latency
    setPins(32'h1234_5678);
    rd(8'h50, d); check("R3 not yet visible", d, 0);
    rd(8'h50, d); check("R3 visible after two edges", d, 32'h1234_5678);

    // R5, R11: level sources under random configuration
    wr(8'h34, 0);
    for (int i = 0; i < 20; i++) begin
      en = $urandom; mask = $urandom; pol = $urandom; p0 = $urandom;
      if (i == 0) begin en = 0; mask = 0; end
      wr(8'h30, en); wr(8'h44, mask); wr(8'h38, pol);
      setPins(p0); idle(3);
      exp = en & ~mask & ~(p0 ^ pol);
      rd(8'h3C, d); check("R5 level status", d, exp);
      check("R11 irq is OR of status", {31'b0, irqOut}, {31'b0, |exp});
    end
    // R7: acknowledge leaves level sources alone
    wr(8'h30, 32'hFFFF_FFFF); wr(8'h44, 0); wr(8'h38, 32'hFFFF_FFFF);
    setPins(32'h00FF_00F0); idle(3);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h3C, d); check("R7 level unaffected by ack", d, 32'h00FF_00F0);

    // R6, R7: edge sources under random configuration
    for (int i = 0; i < 20; i++) begin
      en = $urandom; mask = $urandom; pol = $urandom; p0 = $urandom; p1 = $urandom;
      wr(8'h30, 0);
      wr(8'h34, 32'hFFFF_FFFF); wr(8'h38, pol); wr(8'h44, mask);
      setPins(p0); idle(4);
      wr(8'h30, en);
      setPins(p1); idle(4);
      exp = edgeExp(en, mask, pol, p0, p1);
      rd(8'h3C, d); check("R6 edge latched", d, exp);
      setPins(p0 ^ p1 ^ p1); idle(4);
      rd(8'h3C, d); check("R6 latch holds after pin returns", d, exp | edgeExp(en, mask, pol, p1, p0));
      exp = exp | edgeExp(en, mask, pol, p1, p0);
      ack = $urandom;
      wr(8'h40, ack);
      rd(8'h3C, d); check("R7 ack clears written bits", d, exp & ~ack);
      check("R11 irq after ack", {31'b0, irqOut}, {31'b0, |(exp & ~ack)});
    end

    // R9: masked latch is kept; R10: disable drops it
    wr(8'h30, 0); wr(8'h34, 32'hFFFF_FFFF); wr(8'h38, 32'hFFFF_FFFF); wr(8'h44, 0);
    setPins(0); idle(4);
    wr(8'h30, 32'h0000_0030);
    setPins(32'h0000_0030); idle(4);
    wr(8'h44, 32'h0000_0010);
    rd(8'h3C, d); check("R9 masked hidden", d, 32'h0000_0020);
    wr(8'h44, 0);
    rd(8'h3C, d); check("R9 unmask reveals kept latch", d, 32'h0000_0030);
    wr(8'h30, 32'h0000_0010); wr(8'h30, 32'h0000_0030);
    rd(8'h3C, d); check("R10 disable dropped latch", d, 32'h0000_0010);

    // R8: edge coincides with acknowledge on pin 4 (latch already set)
    wr(8'h30, 32'h0000_0030); wr(8'h40, 32'hFFFF_FFFF);
    setPins(0); idle(4);
    setPins(32'h0000_0010); idle(4);              // latch pin 4
    setPins(0); idle(4);                          // falling: no event
    rd(8'h3C, d); check("R8 precondition latched", d, 32'h0000_0010);
    @(negedge clk); pinIn = 32'h0000_0010;        // rising edge enters sync
    @(negedge clk); busSel = 1; busWrite = 1; busAddr = 8'h40; busWdata = 32'h0000_0010;
    @(negedge clk); busEnable = 1;                // commit coincides with detection
    @(negedge clk); busSel = 0; busEnable = 0; busWrite = 0;
    rd(8'h3C, d); check("R8 edge wins over ack", d, 32'h0000_0010);
    wr(8'h40, 32'h0000_0010);
    rd(8'h3C, d); check("R8 control: lone ack clears", d, 0);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule